// File: doc/BRIEF.md
# Indirect-Access SDRAM Controller Register File

This block is the configuration and status register file of a four-bank SDRAM controller. Software reaches it through only two bus-visible locations. One holds an index (the pointer). The other is a data window that reads or writes whichever internal register the pointer currently selects. Every internal register applies its own write mask when it is written. The two error status words are set by the controller's hardware and cleared by software writing ones. The status word cannot be written; it changes only when the enable bits of the configuration word change. A nonzero ECC error status drives an interrupt line.

The block drives the controller-enable flag and the four bank control words to the rest of the controller. It does not sequence SDRAM commands, generate refresh or compute ECC.

Top module: `memctl_csr`

## Requirements
- R1: An access with `port_data`=0 targets the pointer. A write stores the low `PTR_W` bits of `wdata` (8 by default). A read returns the stored pointer, zero-extended to 32 bits.
- R2: An access with `port_data`=1 acts on the internal register at the current pointer value. The offsets are: 0x00 error status A, 0x08 error status B, 0x10 error address, 0x20 configuration, 0x24 status, 0x30 refresh timer, 0x34 power timer, 0x80 timing, 0x94 ECC configuration, 0x98 ECC error status, and 0x40 + 4·n for bank control word n.
- R3: Each bit of `err_a_set` and `err_b_set` sets the matching bit of its error status word. A data write to an error status word clears the bits written as 1 and leaves bits written as 0 unchanged. A hardware set in the same cycle as a clear wins over the clear.
- R4: The configuration word stores only bits 31:21 of a write (mask 0xFFE00000). `ctrl_en` equals configuration bit 31.
- R5: A configuration write that takes bit 31 from 0 to 1 clears status bit 31. A write that takes bit 31 from 1 to 0 sets status bit 31.
- R6: A configuration write that takes bit 30 from 0 to 1 sets status bit 30. A write that takes bit 30 from 1 to 0 clears status bit 30.
- R7: The status word is read-only. Writes to it are ignored, and it changes only on configuration writes.
- R8: The following words store the write ANDed with their mask:

  | Word | Mask |
  |------|------|
  | Refresh timer | 0x3FF80000 |
  | ECC configuration | 0x00F00000 |
  | ECC error status | 0xFFF0F000 |

  The power timer stores (write AND 0xF8000000) OR 0x07C00000. The error address and the bank control words store the full write. Bank control word n appears on `bank_ctl[32n+31:32n]`.
- R9: `irq` rises when a write takes the ECC error status from zero to nonzero. It falls when a write makes the ECC error status zero.
- R10: A data read of the timing offset returns 0xFFFFFFFF. A data read of any undefined offset also returns 0xFFFFFFFF. Data writes to undefined offsets change nothing.
- R11: After reset the following values hold:

  | Register | Reset value |
  |----------|-------------|
  | Pointer, error status words, error address, status, ECC configuration, ECC error status, bank words | 0 |
  | Configuration | 0x00800000 |
  | Refresh timer | 0x05F00000 |
  | Power timer | 0x07C00000 |
  | `irq` | 0 |
  | `rdata` | 0 |

- R12: `rdata` is registered. It takes the read result at the clock edge that samples a read (`sel`=1, `we`=0) and holds its value through every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel | input | 1 | Access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| port_data | input | 1 | 0 = pointer port, 1 = data window |
| wdata | input | 32 | Write data |
| err_a_set | input | 32 | Hardware set pulses for error status A |
| err_b_set | input | 32 | Hardware set pulses for error status B |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | ECC error interrupt |
| ctrl_en | output | 1 | Controller enable (configuration bit 31) |
| bank_ctl | output | 128 | Four bank control words, word n at bits 32n+31:32n |

## Verification
Each masked register is written with all ones and with all zeros. Comparing the two readbacks separates the mask from the forced-one bits of the power timer. The configuration word is driven through both bits rising together, both falling together, and bit 31 rising alone. This tells apart the inverted sense of status bit 31 and the direct sense of status bit 30, and shows that the two bits are handled independently.

The error words get a hardware set pattern followed by a partial clear, which separates clearing only the ones written from overwriting the word. A clear and a set are also applied in the same cycle to show that the set wins. The pointer is swept over all 256 values. At each value the pointer is read back, and every undefined or timing slot is read and written. This proves that only the listed offsets decode and that stray writes leave the error address and status untouched.

// File: rtl/memctl_csr_pkg.sv
package memctl_csr_pkg;
  localparam int unsigned DW = 32;

  // fixed register slot indices
  localparam int RI_ERRA = 0;
  localparam int RI_ERRB = 1;
  localparam int RI_EADR = 2;
  localparam int RI_CFG  = 3;
  localparam int RI_STAT = 4;
  localparam int RI_RFSH = 5;
  localparam int RI_PWR  = 6;
  localparam int RI_TIM  = 7;
  localparam int RI_ECFG = 8;
  localparam int RI_ESTS = 9;
  localparam int RI_NFIX = 10;

  localparam logic [7:0] OFF_BANK0 = 8'h40;

  localparam logic [DW-1:0] CFG_MASK  = 32'hFFE0_0000;
  localparam logic [DW-1:0] RFSH_MASK = 32'h3FF8_0000;
  localparam logic [DW-1:0] PWR_MASK  = 32'hF800_0000;
  localparam logic [DW-1:0] PWR_FORCE = 32'h07C0_0000;
  localparam logic [DW-1:0] ECFG_MASK = 32'h00F0_0000;
  localparam logic [DW-1:0] ESTS_MASK = 32'hFFF0_F000;

  localparam logic [DW-1:0] CFG_RST  = 32'h0080_0000;
  localparam logic [DW-1:0] RFSH_RST = 32'h05F0_0000;
  localparam logic [DW-1:0] PWR_RST  = 32'h07C0_0000;

  localparam int EN_BIT  = 31;
  localparam int AUX_BIT = 30;

  function automatic logic [7:0] fix_off(input int idx);
    case (idx)
      RI_ERRA: fix_off = 8'h00;
      RI_ERRB: fix_off = 8'h08;
      RI_EADR: fix_off = 8'h10;
      RI_CFG:  fix_off = 8'h20;
      RI_STAT: fix_off = 8'h24;
      RI_RFSH: fix_off = 8'h30;
      RI_PWR:  fix_off = 8'h34;
      RI_TIM:  fix_off = 8'h80;
      RI_ECFG: fix_off = 8'h94;
      default: fix_off = 8'h98;
    endcase
  endfunction
endpackage

// File: rtl/memctl_csr_dec.sv
module memctl_csr_dec
  import memctl_csr_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int NBANK = 4
) (
  input  logic [PTR_W-1:0]   ptr,
  output logic [RI_NFIX-1:0] fix_hit,
  output logic [NBANK-1:0]   bank_hit
);
  for (genvar i = 0; i < RI_NFIX; i++) begin : g_fix
    assign fix_hit[i] = (ptr == PTR_W'(fix_off(i)));
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_hit[b] = (ptr == PTR_W'(int'(OFF_BANK0) + 4 * b));
  end

  // R2
  always_comb begin
    one_slot_chk: assert ($onehot0({fix_hit, bank_hit}));
  end
endmodule

// File: rtl/memctl_csr_store.sv
module memctl_csr_store
  import memctl_csr_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [RI_NFIX-1:0]           fix_hit,
  input  logic [NBANK-1:0]             bank_hit,
  input  logic [DW-1:0]                wdata,
  input  logic [DW-1:0]                err_a_set,
  input  logic [DW-1:0]                err_b_set,
  output logic [RI_NFIX-1:0][DW-1:0]   fix_val,
  output logic [NBANK-1:0][DW-1:0]     bank_val,
  output logic                         irq_o,
  output logic                         en_o
);
  logic [DW-1:0] erra_q, erra_d, errb_q, errb_d, eadr_q;
  logic [DW-1:0] cfg_q, cfg_d, stat_q, stat_d;
  logic [DW-1:0] rfsh_q, pwr_q, ecfg_q, ests_q, ests_d;
  logic          irq_q, irq_d;
  logic          wr_erra, wr_errb, wr_eadr, wr_cfg, wr_rfsh, wr_pwr, wr_ecfg, wr_ests;

  assign wr_erra = wr_en && fix_hit[RI_ERRA];
  assign wr_errb = wr_en && fix_hit[RI_ERRB];
  assign wr_eadr = wr_en && fix_hit[RI_EADR];
  assign wr_cfg  = wr_en && fix_hit[RI_CFG];
  assign wr_rfsh = wr_en && fix_hit[RI_RFSH];
  assign wr_pwr  = wr_en && fix_hit[RI_PWR];
  assign wr_ecfg = wr_en && fix_hit[RI_ECFG];
  assign wr_ests = wr_en && fix_hit[RI_ESTS];

  // next-state
  always_comb begin
    erra_d = (erra_q & ~(wr_erra ? wdata : '0)) | err_a_set;
    errb_d = (errb_q & ~(wr_errb ? wdata : '0)) | err_b_set;
    cfg_d  = cfg_q;
    stat_d = stat_q;
    if (wr_cfg) begin
      cfg_d = wdata & CFG_MASK;
      if (!cfg_q[EN_BIT] && cfg_d[EN_BIT])      stat_d[EN_BIT] = 1'b0;
      else if (cfg_q[EN_BIT] && !cfg_d[EN_BIT]) stat_d[EN_BIT] = 1'b1;
      if (!cfg_q[AUX_BIT] && cfg_d[AUX_BIT])      stat_d[AUX_BIT] = 1'b1;
      else if (cfg_q[AUX_BIT] && !cfg_d[AUX_BIT]) stat_d[AUX_BIT] = 1'b0;
    end
    ests_d = wdata & ESTS_MASK;
    irq_d  = irq_q;
    if (ests_q == '0 && ests_d != '0)      irq_d = 1'b1;
    else if (ests_q != '0 && ests_d == '0) irq_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erra_q <= '0;
      errb_q <= '0;
    end else begin
      erra_q <= erra_d;
      errb_q <= errb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      stat_q <= '0;
    end else if (wr_cfg) begin
      cfg_q  <= cfg_d;
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eadr_q <= '0;
    else if (wr_eadr) eadr_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rfsh_q <= RFSH_RST;
    else if (wr_rfsh) rfsh_q <= wdata & RFSH_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= PWR_RST;
    else if (wr_pwr) pwr_q <= (wdata & PWR_MASK) | PWR_FORCE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecfg_q <= '0;
    else if (wr_ecfg) ecfg_q <= wdata & ECFG_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ests_q <= '0;
      irq_q  <= 1'b0;
    end else if (wr_ests) begin
      ests_q <= ests_d;
      irq_q  <= irq_d;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] bank_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q <= '0;
      else if (wr_en && bank_hit[b]) bank_q <= wdata;
    end
    assign bank_val[b] = bank_q;
  end

  always_comb begin
    fix_val          = '0;
    fix_val[RI_ERRA] = erra_q;
    fix_val[RI_ERRB] = errb_q;
    fix_val[RI_EADR] = eadr_q;
    fix_val[RI_CFG]  = cfg_q;
    fix_val[RI_STAT] = stat_q;
    fix_val[RI_RFSH] = rfsh_q;
    fix_val[RI_PWR]  = pwr_q;
    fix_val[RI_TIM]  = '1;
    fix_val[RI_ECFG] = ecfg_q;
    fix_val[RI_ESTS] = ests_q;
  end

  assign irq_o = irq_q;
  assign en_o  = cfg_q[EN_BIT];

  // R3
  erra_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_erra |=> ((erra_q & $past(erra_q)) == $past(erra_q)));
  // R3
  errb_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((errb_q & $past(err_b_set)) == $past(err_b_set)));
  // R5
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !cfg_q[EN_BIT] && wdata[EN_BIT]) |=> !stat_q[EN_BIT]);
  // R6
  aux_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && !cfg_q[AUX_BIT] && wdata[AUX_BIT]) |=> stat_q[AUX_BIT]);
  // R7
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(stat_q));
  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (irq_q == (ests_q != '0)));
endmodule

// File: rtl/memctl_csr_rd.sv
module memctl_csr_rd
  import memctl_csr_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int NBANK = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_req,
  input  logic                       port_data,
  input  logic [PTR_W-1:0]           ptr,
  input  logic [RI_NFIX-1:0]         fix_hit,
  input  logic [NBANK-1:0]           bank_hit,
  input  logic [RI_NFIX-1:0][DW-1:0] fix_val,
  input  logic [NBANK-1:0][DW-1:0]   bank_val,
  output logic [DW-1:0]              rdata
);
  localparam int PAD_W = DW - PTR_W;

  logic [DW-1:0] win_val, rd_d, rd_q;
  logic          miss;

  always_comb begin
    win_val = '1;
    for (int i = 0; i < RI_NFIX; i++)
      if (fix_hit[i]) win_val = fix_val[i];
    for (int b = 0; b < NBANK; b++)
      if (bank_hit[b]) win_val = bank_val[b];
  end

  assign miss = !(|fix_hit) && !(|bank_hit);

  always_comb begin
    rd_d = rd_q;
    if (rd_req) rd_d = port_data ? win_val : {{PAD_W{1'b0}}, ptr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (rd_req) rd_q <= rd_d;
  end

  assign rdata = rd_q;

  // R1
  ptr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !port_data) |=> (rdata == {{PAD_W{1'b0}}, $past(ptr)}));
  // R10
  miss_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && port_data && (miss || fix_hit[RI_TIM])) |=> (rdata == '1));
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rdata));
endmodule

// File: rtl/memctl_csr.sv
module memctl_csr
  import memctl_csr_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int NBANK = 4,
  localparam int BW = NBANK * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          we,
  input  logic          port_data,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] err_a_set,
  input  logic [DW-1:0] err_b_set,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          ctrl_en,
  output logic [BW-1:0] bank_ctl
);
  logic [PTR_W-1:0]           ptr_q, ptr_d;
  logic                       ptr_wr, data_wr, rd_req;
  logic [RI_NFIX-1:0]         fix_hit;
  logic [NBANK-1:0]           bank_hit;
  logic [RI_NFIX-1:0][DW-1:0] fix_val;
  logic [NBANK-1:0][DW-1:0]   bank_val;

  assign ptr_wr  = sel && we && !port_data;
  assign data_wr = sel && we && port_data;
  assign rd_req  = sel && !we;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_wr) ptr_d = wdata[PTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (ptr_wr) ptr_q <= ptr_d;
  end

  memctl_csr_dec #(.PTR_W(PTR_W), .NBANK(NBANK)) u_dec (
    .ptr      (ptr_q),
    .fix_hit  (fix_hit),
    .bank_hit (bank_hit)
  );

  memctl_csr_store #(.NBANK(NBANK)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (data_wr),
    .fix_hit   (fix_hit),
    .bank_hit  (bank_hit),
    .wdata     (wdata),
    .err_a_set (err_a_set),
    .err_b_set (err_b_set),
    .fix_val   (fix_val),
    .bank_val  (bank_val),
    .irq_o     (irq),
    .en_o      (ctrl_en)
  );

  memctl_csr_rd #(.PTR_W(PTR_W), .NBANK(NBANK)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .port_data (port_data),
    .ptr       (ptr_q),
    .fix_hit   (fix_hit),
    .bank_hit  (bank_hit),
    .fix_val   (fix_val),
    .bank_val  (bank_val),
    .rdata     (rdata)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_out
    assign bank_ctl[b*DW +: DW] = bank_val[b];
  end

  // R4
  en_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && fix_hit[RI_CFG]) |=> (ctrl_en == $past(wdata[EN_BIT])));
endmodule

// File: tb/memctl_csr_test.sv
module memctl_csr_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n, sel, we, port_data;
  logic [31:0]  wdata, err_a_set, err_b_set, rdata;
  logic         irq, ctrl_en;
  logic [127:0] bank_ctl;
  int           n_run = 0;
  int           n_fail = 0;
  logic [31:0]  rv;

  memctl_csr uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .port_data(port_data),
    .wdata(wdata), .err_a_set(err_a_set), .err_b_set(err_b_set),
    .rdata(rdata), .irq(irq), .ctrl_en(ctrl_en), .bank_ctl(bank_ctl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic acc(input logic p, input logic w, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = w; port_data = p; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic wr_ptr(input logic [31:0] d); acc(1'b0, 1'b1, d); endtask
  task automatic wr_dat(input logic [31:0] d); acc(1'b1, 1'b1, d); endtask
  task automatic rd_ptr(output logic [31:0] v); acc(1'b0, 1'b0, '0); v = rdata; endtask
  task automatic rd_dat(output logic [31:0] v); acc(1'b1, 1'b0, '0); v = rdata; endtask

  task automatic wr_reg(input logic [7:0] off, input logic [31:0] d);
    wr_ptr({24'h0, off}); wr_dat(d);
  endtask
  task automatic rd_reg(input logic [7:0] off, output logic [31:0] v);
    wr_ptr({24'h0, off}); rd_dat(v);
  endtask

  function automatic bit is_def(input int p);
    return (p == 'h00 || p == 'h08 || p == 'h10 || p == 'h20 || p == 'h24 ||
            p == 'h30 || p == 'h34 || p == 'h40 || p == 'h44 || p == 'h48 ||
            p == 'h4C || p == 'h94 || p == 'h98);
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got 00000000 expected 00000001");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel = 1'b0; we = 1'b0; port_data = 1'b0;
    wdata = '0; err_a_set = '0; err_b_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 rdata", rdata, 32'h0);
    chk("R11 irq", {31'h0, irq}, 32'h0);
    chk("R11 ctrl_en", {31'h0, ctrl_en}, 32'h0);
    chk("R11 banks", bank_ctl[31:0] | bank_ctl[63:32] | bank_ctl[95:64] | bank_ctl[127:96], 32'h0);
    rd_ptr(rv); chk("R11 ptr", rv, 32'h0);
    rd_reg(8'h00, rv); chk("R11 errA", rv, 32'h0);
    rd_reg(8'h08, rv); chk("R11 errB", rv, 32'h0);
    rd_reg(8'h10, rv); chk("R11 eadr", rv, 32'h0);
    rd_reg(8'h20, rv); chk("R11 cfg", rv, 32'h0080_0000);
    rd_reg(8'h24, rv); chk("R11 stat", rv, 32'h0);
    rd_reg(8'h30, rv); chk("R11 rfsh", rv, 32'h05F0_0000);
    rd_reg(8'h34, rv); chk("R11 pwr", rv, 32'h07C0_0000);
    rd_reg(8'h94, rv); chk("R11 ecfg", rv, 32'h0);
    rd_reg(8'h98, rv); chk("R11 ests", rv, 32'h0);
    for (int b = 0; b < 4; b++) begin
      rd_reg(8'h40 + 8'(4*b), rv); chk("R11 bank", rv, 32'h0);
    end

    // R8 masks: all ones then all zeros
    wr_reg(8'h30, '1); rd_dat(rv); chk("R8 rfsh ones", rv, 32'h3FF8_0000);
    wr_dat('0);        rd_dat(rv); chk("R8 rfsh zero", rv, 32'h0);
    wr_reg(8'h34, '1); rd_dat(rv); chk("R8 pwr ones", rv, 32'hFFC0_0000);
    wr_dat('0);        rd_dat(rv); chk("R8 pwr zero", rv, 32'h07C0_0000);
    wr_reg(8'h94, '1); rd_dat(rv); chk("R8 ecfg ones", rv, 32'h00F0_0000);
    wr_dat('0);        rd_dat(rv); chk("R8 ecfg zero", rv, 32'h0);
    wr_reg(8'h10, 32'h1234_5678); rd_dat(rv); chk("R8 eadr", rv, 32'h1234_5678);
    for (int b = 0; b < 4; b++) begin
      logic [31:0] pat;
      pat = 32'h1111_1111 * (b + 1) ^ 32'h8000_0001;
      wr_reg(8'h40 + 8'(4*b), pat); rd_dat(rv);
      chk("R8 bank read", rv, pat);
      chk("R8 bank port", bank_ctl[b*32 +: 32], pat);
    end

    // R9 interrupt
    wr_reg(8'h98, 32'h0000_0FFF);
    chk("R9 masked-off write keeps irq low", {31'h0, irq}, 32'h0);
    wr_dat('1); rd_dat(rv);
    chk("R9 ests mask", rv, 32'hFFF0_F000);
    chk("R9 irq rise", {31'h0, irq}, 32'h1);
    wr_dat(32'h0000_1000);
    chk("R9 irq stays", {31'h0, irq}, 32'h1);
    wr_dat('0);
    chk("R9 irq fall", {31'h0, irq}, 32'h0);

    // R4 R5 R6 configuration edges
    wr_reg(8'h20, '1); rd_dat(rv);
    chk("R4 cfg mask", rv, 32'hFFE0_0000);
    chk("R4 ctrl_en on", {31'h0, ctrl_en}, 32'h1);
    rd_reg(8'h24, rv); chk("R5 R6 both rise", rv, 32'h4000_0000);
    wr_reg(8'h20, '0);
    chk("R4 ctrl_en off", {31'h0, ctrl_en}, 32'h0);
    rd_reg(8'h24, rv); chk("R5 R6 both fall", rv, 32'h8000_0000);
    wr_reg(8'h20, 32'h8000_0000);
    rd_reg(8'h24, rv); chk("R5 en rise alone", rv, 32'h0);
    wr_reg(8'h20, 32'hC000_0000);
    rd_reg(8'h24, rv); chk("R6 aux rise alone", rv, 32'h4000_0000);

    // R7 status read-only
    wr_reg(8'h24, '1); rd_dat(rv); chk("R7 stat ignore ones", rv, 32'h4000_0000);
    wr_dat('0);        rd_dat(rv); chk("R7 stat ignore zero", rv, 32'h4000_0000);

    // R3 error words
    @(negedge clk); err_a_set = 32'hA5A5_0F0F; err_b_set = 32'h0000_00F0;
    @(negedge clk); err_a_set = '0; err_b_set = '0;
    rd_reg(8'h00, rv); chk("R3 errA set", rv, 32'hA5A5_0F0F);
    wr_dat(32'h0000_FFFF); rd_dat(rv); chk("R3 errA partial clear", rv, 32'hA5A5_0000);
    wr_dat('1); rd_dat(rv); chk("R3 errA full clear", rv, 32'h0);
    rd_reg(8'h08, rv); chk("R3 errB set", rv, 32'h0000_00F0);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; port_data = 1'b1; wdata = 32'h0000_00FF; err_b_set = 32'h0000_0081;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; wdata = '0; err_b_set = '0;
    rd_dat(rv); chk("R3 set beats clear", rv, 32'h0000_0081);

    // R12 rdata holds across non-read accesses
    wr_ptr(32'h0000_0010);
    chk("R12 hold after ptr write", rdata, 32'h0000_0081);
    wr_dat(32'h1234_5678);
    chk("R12 hold after data write", rdata, 32'h0000_0081);

    // R1 R2 R10 sweep of every pointer value
    for (int p = 0; p < 256; p++) begin
      wr_ptr(32'hFFFF_FF00 | 32'(p)); rd_ptr(rv);
      chk("R1 ptr readback", rv, 32'(p));
      if (!is_def(p)) begin
        rd_dat(rv); chk("R10 undefined/timing read", rv, 32'hFFFF_FFFF);
        wr_dat('1);
      end
    end
    rd_reg(8'h10, rv); chk("R10 eadr untouched", rv, 32'h1234_5678);
    rd_reg(8'h24, rv); chk("R10 stat untouched", rv, 32'h4000_0000);
    rd_reg(8'h20, rv); chk("R2 cfg kept", rv, 32'hC000_0000);
    rd_reg(8'h4C, rv); chk("R2 bank3 kept", rv, 32'h4444_4444 ^ 32'h8000_0001);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule